// File: doc/BRIEF.md
# Banked Byte Register Space with Indirect Extended Memory

This block is the byte-wide register space that a processor sees on a clock peripheral. A 7-bit offset selects one of 128 locations. The first 14 locations hold clock and control bytes, which are modelled here as plain storage. The remaining locations hold general-purpose user bytes that have no side effects. A bank-select bit lives in one of the control bytes and changes how the upper part of the window is decoded.

With bank 0 selected, the whole 128-byte window is direct: clock bytes at offsets 0x00–0x0D and user bytes at offsets 0x0E–0x7F. With bank 1 selected, the lower part of the window stays direct. The upper part turns into an indirect path into a larger extended byte array: two address bytes form a 13-bit pointer, and a data port reads or writes the array at that pointer. The size of the extended array is a parameter of 2, 4 or 8 KiB, and the pointer wraps modulo that size.

The bus is synchronous. Each cycle carries an offset, write data, a write strobe and a read strobe. A read returns its byte on `busRdData` one cycle after the strobe, and that byte holds until the next read. No access is ever stalled, so user bytes stay readable and writable at any time.

Top module: `banked_reg_space`

## Requirements
- R1: After reset, every clock/control byte reads 0x00, the bank bit is 0, the extended pointer is 0 and `busRdData` is 0x00.
- R2: In bank 0, offsets 0x00–0x0D store clock/control bytes and offsets 0x0E–0x7F store user bytes. A write takes effect at the clock edge where `busWrEn` is high. A read samples at the edge where `busRdEn` is high, and `busRdData` holds that byte until the next read strobe.
- R3: The bank-select bit is bit 4 of the control byte at offset 0x0A (1 = bank 1). A new value written there governs decode from the next access onward.
- R4: In bank 1, offsets 0x00–0x3F decode exactly as in bank 0 (clock bytes, then user bytes 0x0E–0x3F).
- R5: In bank 1, offset 0x50 reads and writes pointer bits 7:0. Offset 0x51 writes pointer bits 12:8 from write-data bits 4:0, and reads back as {3'b000, pointer[12:8]}.
- R6: In bank 1, offset 0x53 is the data port. It reads or writes the extended byte at the current pointer and leaves the pointer unchanged.
- R7: The extended array holds EXT_KBYTES×1024 bytes (EXT_KBYTES is 2, 4 or 8), and the data port uses the pointer modulo that size.
- R8: In bank 1, every offset in 0x40–0x7F other than 0x50, 0x51 and 0x53 reads 0x00 and ignores writes. The user bytes at those offsets keep their contents.
- R9: User bytes and extended bytes never alias. A bank-0 write to any user offset, including 0x50, 0x51 and 0x53, changes neither the pointer nor the extended array.
- R10: When read and write strobes are both high at one edge on the same offset, the read returns the byte stored before that write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 7 | Byte offset within the 128-byte window |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, valid the cycle after the read strobe and held until the next one |

## Verification
The hardest condition to reach from the ports is a data-port access whose pointer has bits set above the configured array size, made while user bytes at the same offsets hold distinct known values. Reaching it needs a bank switch and two pointer writes in front of the access. The bench first fills every user byte in bank 0 and every extended byte through the three-write indirect sequence, each with its own address-derived pattern, so that any wrap, alias or stray write turns up as a wrong byte. It then drives directed pointers above the array size, bank-0 writes to the offsets that bank 1 uses for its pointer and data port, and a long random mix of accesses at random offsets, including random writes to the bank byte, all checked against a bench model.

// File: rtl/bank_space_pkg.sv
package bank_space_pkg;

  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int CLOCK_REGS = 14;
  localparam int USER_BYTES = (1 << ADDR_W) - CLOCK_REGS;
  localparam int PTR_W      = 13;
  localparam int BANK_REG   = 10;
  localparam int BANK_BIT   = 4;

  localparam logic [ADDR_W-1:0] USER_BASE    = ADDR_W'(CLOCK_REGS);
  localparam logic [ADDR_W-1:0] SHARED_LIMIT = 7'h40;
  localparam logic [ADDR_W-1:0] PTR_LO_OFF   = 7'h50;
  localparam logic [ADDR_W-1:0] PTR_HI_OFF   = 7'h51;
  localparam logic [ADDR_W-1:0] DATA_OFF     = 7'h53;
  localparam logic [ADDR_W-1:0] BANK_OFF     = ADDR_W'(BANK_REG);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CLOCK,
    SEL_USER,
    SEL_PTR_LO,
    SEL_PTR_HI,
    SEL_DATA
  } rdSel_e;

  typedef struct packed {
    logic   clockWr;
    logic   userWr;
    logic   ptrLoWr;
    logic   ptrHiWr;
    logic   dataWr;
    logic   rdEn;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/bank_space_ctrl.sv
module bank_space_ctrl
  import bank_space_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              bankSel,
  output strobes_t          st
);

  rdSel_e target;

  // Offset decode: the bank bit only changes the meaning of 0x40..0x7F.
  always_comb begin
    target = SEL_NONE;
    if (addr < USER_BASE) begin
      target = SEL_CLOCK;
    end else if (!bankSel || addr < SHARED_LIMIT) begin
      target = SEL_USER;
    end else if (addr == PTR_LO_OFF) begin
      target = SEL_PTR_LO;
    end else if (addr == PTR_HI_OFF) begin
      target = SEL_PTR_HI;
    end else if (addr == DATA_OFF) begin
      target = SEL_DATA;
    end
  end

  always_comb begin
    st         = '0;
    st.rdSel   = target;
    st.rdEn    = rdEn;
    st.clockWr = wrEn && (target == SEL_CLOCK);
    st.userWr  = wrEn && (target == SEL_USER);
    st.ptrLoWr = wrEn && (target == SEL_PTR_LO);
    st.ptrHiWr = wrEn && (target == SEL_PTR_HI);
    st.dataWr  = wrEn && (target == SEL_DATA);
  end

  // R2: a write lands in at most one storage element
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.clockWr, st.userWr, st.ptrLoWr, st.ptrHiWr, st.dataWr}));

  // R9: bank 0 never reaches the indirect path
  assert_bank0_no_indirect_R9: assert property (@(posedge clk) disable iff (!rstN)
    !bankSel |-> !(st.ptrLoWr || st.ptrHiWr || st.dataWr));

  // R8: unmapped bank-1 offsets write nothing
  assert_hole_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel && wrEn && addr >= SHARED_LIMIT && addr != PTR_LO_OFF &&
     addr != PTR_HI_OFF && addr != DATA_OFF)
    |-> !(st.clockWr || st.userWr || st.ptrLoWr || st.ptrHiWr || st.dataWr));

endmodule

// File: rtl/bank_space_dp.sv
module bank_space_dp
  import bank_space_pkg::*;
#(
  parameter int EXT_KBYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  strobes_t          st,
  output logic              bankSel,
  output logic [DATA_W-1:0] rdData
);

  localparam int EXT_BYTES = EXT_KBYTES * 1024;
  localparam int EXT_AW    = $clog2(EXT_BYTES);
  localparam int HI_W      = PTR_W - 8;

  logic [DATA_W-1:0] clockRegs [CLOCK_REGS];
  logic [DATA_W-1:0] userRam   [USER_BYTES];
  logic [DATA_W-1:0] extRam    [EXT_BYTES];
  logic [PTR_W-1:0]  extPtr;
  logic [ADDR_W-1:0] userIdx;
  logic [EXT_AW-1:0] extIdx;

  assign userIdx = addr - USER_BASE;
  assign extIdx  = extPtr[EXT_AW-1:0];
  assign bankSel = clockRegs[BANK_REG][BANK_BIT];

  // Clock/control bytes: plain resettable storage, one register per slot.
  for (genvar i = 0; i < CLOCK_REGS; i++) begin : g_clock
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (st.clockWr && addr == ADDR_W'(i)) begin
        q <= wrData;
      end
    end
    assign clockRegs[i] = q;
  end

  // User bytes: no reset, always accessible.
  always_ff @(posedge clk) begin
    if (st.userWr) begin
      userRam[userIdx] <= wrData;
    end
  end

  // Extended array reached only through the data port.
  always_ff @(posedge clk) begin
    if (st.dataWr) begin
      extRam[extIdx] <= wrData;
    end
  end

  // 13-bit pointer written a byte at a time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPtr <= '0;
    end else begin
      if (st.ptrLoWr) extPtr[7:0] <= wrData;
      if (st.ptrHiWr) extPtr[PTR_W-1:8] <= wrData[HI_W-1:0];
    end
  end

  // Registered read, held between read strobes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (st.rdEn) begin
      unique case (st.rdSel)
        SEL_CLOCK:  rdData <= clockRegs[addr[3:0]];
        SEL_USER:   rdData <= userRam[userIdx];
        SEL_PTR_LO: rdData <= extPtr[7:0];
        SEL_PTR_HI: rdData <= {{(8-HI_W){1'b0}}, extPtr[PTR_W-1:8]};
        SEL_DATA:   rdData <= extRam[extIdx];
        default:    rdData <= '0;
      endcase
    end
  end

  // R2: read data holds without a read strobe
  assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdEn |=> $stable(rdData));

  // R3: bank bit follows the write to its control byte
  assert_bank_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.clockWr && addr == BANK_OFF) |=> bankSel == $past(wrData[BANK_BIT]));

  // R5: high pointer byte keeps only its five low bits
  assert_ptr_hi_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.ptrHiWr |=> extPtr[PTR_W-1:8] == $past(wrData[HI_W-1:0]));

  // R6: pointer is changed only by its own offsets
  assert_ptr_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(st.ptrLoWr || st.ptrHiWr) |=> $stable(extPtr));

endmodule

// File: rtl/banked_reg_space.sv
module banked_reg_space
  import bank_space_pkg::*;
#(
  parameter int EXT_KBYTES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] busAddr,
  input  logic [7:0] busWrData,
  input  logic       busWrEn,
  input  logic       busRdEn,
  output logic [7:0] busRdData
);

  strobes_t st;
  logic     bankSel;

  // R7: only the three supported array sizes
  initial begin
    assert_ext_size_R7: assert (EXT_KBYTES == 2 || EXT_KBYTES == 4 || EXT_KBYTES == 8);
  end

  bank_space_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (busAddr),
    .wrEn    (busWrEn),
    .rdEn    (busRdEn),
    .bankSel (bankSel),
    .st      (st)
  );

  bank_space_dp #(.EXT_KBYTES(EXT_KBYTES)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (busAddr),
    .wrData  (busWrData),
    .st      (st),
    .bankSel (bankSel),
    .rdData  (busRdData)
  );

endmodule

// File: tb/test_banked_reg_space.sv
`timescale 1ns/1ps
module test_banked_reg_space;

  localparam int EXT_KB    = 2;
  localparam int EXT_BYTES = EXT_KB * 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  logic [7:0]  mClock [14];
  logic [7:0]  mUser  [114];
  logic [7:0]  mExt   [EXT_BYTES];
  logic [12:0] mPtr;

  always #2 clk = ~clk;

  banked_reg_space #(.EXT_KBYTES(EXT_KB)) i_banked_reg_space (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData)
  );

  function automatic logic [7:0] userPat(int a);
    return 8'((a * 37 + 5) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] extPat(int i);
    return 8'((i * 13) ^ (i >> 7) ^ 8'hC3);
  endfunction

  function automatic bit mBank();
    return mClock[10][4];
  endfunction

  function automatic logic [7:0] expRead(logic [6:0] a);
    if (a < 7'd14) return mClock[a];
    if (!mBank() || a < 7'h40) return mUser[a - 7'd14];
    if (a == 7'h50) return mPtr[7:0];
    if (a == 7'h51) return {3'b000, mPtr[12:8]};
    if (a == 7'h53) return mExt[mPtr % EXT_BYTES];
    return 8'h00;
  endfunction

  task automatic modelWrite(logic [6:0] a, logic [7:0] d);
    if (a < 7'd14) mClock[a] = d;
    else if (!mBank() || a < 7'h40) mUser[a - 7'd14] = d;
    else if (a == 7'h50) mPtr[7:0] = d;
    else if (a == 7'h51) mPtr[12:8] = d[4:0];
    else if (a == 7'h53) mExt[mPtr % EXT_BYTES] = d;
  endtask

  task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic [6:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic doRead(logic [6:0] a, string tag);
    logic [7:0] exp;
    exp = expRead(a);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    check(busRdData, exp, tag);
  endtask

  task automatic doRdWr(logic [6:0] a, logic [7:0] d, string tag);
    logic [7:0] exp;
    exp = expRead(a);
    busAddr = a; busWrData = d; busWrEn = 1'b1; busRdEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
    modelWrite(a, d);
    check(busRdData, exp, tag);
  endtask

  task automatic setBank(bit b);
    doWrite(7'h0A, {mClock[10][7:5], b, mClock[10][3:0]});
  endtask

  task automatic setPtr(logic [12:0] p);
    doWrite(7'h50, p[7:0]);
    doWrite(7'h51, {3'b000, p[12:8]});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 14; i++) mClock[i] = 8'h00;
    mPtr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(busRdData, 8'h00, "R1 rdData after reset");
    doRead(7'h0A, "R1 bank byte");
    doRead(7'h03, "R1 clock byte");
    setBank(1'b1);
    doRead(7'h50, "R1 pointer low");
    doRead(7'h51, "R1 pointer high");
    setBank(1'b0);

    // R2: fill bank-0 view
    for (int a = 14; a < 128; a++) doWrite(7'(a), userPat(a));
    for (int a = 0; a < 14; a++) doWrite(7'(a), (a == 10) ? 8'h2B : 8'(a * 17 + 1));
    doRead(7'h0E, "R2 first user byte");
    doRead(7'h7F, "R2 last user byte");
    doRead(7'h53, "R2 user byte at data-port offset");
    doRead(7'h0D, "R2 last clock byte");
    busAddr = 7'h20;
    @(negedge clk);
    check(busRdData, mClock[13], "R2 read data held");

    // R3: bank switch and fill the extended array
    setBank(1'b1);
    doRead(7'h0A, "R3 bank bit readback");
    for (int i = 0; i < EXT_BYTES; i++) begin
      setPtr(13'(i));
      doWrite(7'h53, extPat(i));
    end

    // R4: shared lower window in bank 1
    doRead(7'h05, "R4 clock byte in bank 1");
    doRead(7'h0E, "R4 user byte in bank 1");
    doRead(7'h3F, "R4 top shared user byte");

    // R5: pointer bytes
    doWrite(7'h51, 8'hFF);
    doRead(7'h51, "R5 high pointer masked");
    doWrite(7'h50, 8'hAB);
    doRead(7'h50, "R5 low pointer");

    // R6/R7: data port at pointer 0x1FAB wraps into the array
    doRead(7'h53, "R7 wrapped read");
    check(expRead(7'h53), extPat(12'h7AB), "R7 model wrap sanity");
    doRead(7'h53, "R6 repeat read same byte");
    doRead(7'h50, "R6 pointer unchanged by read");
    doWrite(7'h53, 8'h3C);
    doRead(7'h51, "R6 pointer unchanged by write");
    setPtr(13'h0805);
    doWrite(7'h53, 8'h96);
    setPtr(13'h0005);
    doRead(7'h53, "R7 alias of wrapped write");

    // R8: holes in bank 1
    doWrite(7'h60, 8'h77);
    doRead(7'h60, "R8 hole reads zero");
    doWrite(7'h52, 8'h11);
    doRead(7'h52, "R8 hole 0x52 reads zero");
    doRead(7'h7F, "R8 top hole reads zero");
    setBank(1'b0);
    doRead(7'h60, "R8 user byte survives hole write");
    doRead(7'h52, "R8 user byte 0x52 intact");

    // R9: bank-0 writes at indirect offsets do not touch the indirect path
    doWrite(7'h50, 8'hE1);
    doWrite(7'h51, 8'hE2);
    doWrite(7'h53, 8'hE3);
    doRead(7'h53, "R9 user byte at 0x53");
    setBank(1'b1);
    doRead(7'h50, "R9 pointer low untouched");
    doRead(7'h51, "R9 pointer high untouched");
    doRead(7'h53, "R9 extended byte untouched");
    setBank(1'b0);

    // R10: simultaneous read and write
    doRdWr(7'h20, 8'h5D, "R10 read returns old byte");
    doRead(7'h20, "R10 write took effect");
    doRdWr(7'h04, 8'hC7, "R10 clock byte old value");
    doRead(7'h04, "R10 clock byte new value");

    // Random mix across both banks
    for (int n = 0; n < 1500; n++) begin
      logic [6:0] a;
      int op;
      op = $urandom_range(0, 9);
      a = 7'($urandom_range(0, 127));
      if (op == 0) setBank(1'($urandom_range(0, 1)));
      else if (op == 1) setPtr(13'($urandom));
      else if (op < 5) doWrite(a, 8'($urandom));
      else if (op < 9) doRead(a, "R2/R4/R6/R8 random read");
      else doRdWr(a, 8'($urandom), "R10 random read-write");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule